// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Unit

This block watches the count of an external free-running timer and compares it against two programmable reference values, a primary and a secondary. It drives a single output pin and a single-cycle interrupt pulse. A 3-bit mode selector chooses one of eight behaviours: off, two single-edge one-shots, toggle, a delayed one-shot, a repeating pulse, and pulse-width modulation with or without a fault guard. When the block is off it hands the pin back to a general-purpose fallback level.

The timer is assumed to restart from zero on the cycle after it raises its period-match strobe, so matches can recur once per period. In the two PWM modes the pin goes high at each period start and low when the count reaches a duty value. That duty value comes from the secondary register, but it only takes effect at a period boundary or on mode entry. Mode changes are meant to happen while the timer is stopped. Every change of the selector applies the new mode's starting pin level.

Top module: `cmpout_top`

## Requirements
- R1: Selector 3'b000 is off: `pin_drive` is 0, `pin_out` equals `gpio_val`, and `irq_pulse` stays 0 whatever the timer does.
- R2: Selector 3'b001 starts with the pin at 0. The first cycle whose count equals the primary value sets the pin to 1 on the next edge, with one interrupt pulse in the same cycle. Later matches change nothing.
- R3: Selector 3'b010 starts with the pin at 1. The first primary match clears the pin, with one interrupt pulse in the same cycle, and later matches change nothing.
- R4: Selector 3'b011 keeps the pin level it had on entry. Every primary match inverts the pin and gives one interrupt pulse.
- R5: Selector 3'b100 starts at 0. The pin rises on a primary match and falls on the next secondary match, and then stays low. The only interrupt comes with the fall.
- R6: Selector 3'b101 behaves like R5 but repeats the rise and fall in every timer period, with an interrupt on each fall.
- R7: On entry to 3'b110 or 3'b111 the pin is 0 if the primary value is zero and 1 otherwise.
- R8: In both PWM modes the pin is set at the period-match strobe (to 1 unless the new duty is zero) and cleared when the count equals the active duty. The active duty copies the secondary value only at the strobe or on mode entry, so a write in mid-period does not move the current period's fall.
- R9: Selector 3'b110 never raises an interrupt.
- R10: In 3'b111 a low level on `fault_n` forces the pin to 0 and holds it low through later periods until the selector is rewritten. A falling edge on `fault_n` gives one interrupt pulse.
- R11: `irq_pulse` is high for one cycle per qualifying pin event, and a change of the selector never raises it.
- R12: During and right after reset the block is off: `pin_drive` and `irq_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | CNT_W | Current count of the external timer |
| prd_hit | input | 1 | Timer period-match strobe; the count is zero on the next cycle |
| mode_sel | input | 3 | Mode selector (encoding in R1 to R10) |
| cmp_pri | input | CNT_W | Primary compare value |
| cmp_sec | input | CNT_W | Secondary compare value, also the PWM duty source |
| fault_n | input | 1 | Active-low fault input used in 3'b111 |
| gpio_val | input | 1 | Fallback pin level while the block is off |
| pin_out | output | 1 | Resulting pin level |
| pin_drive | output | 1 | High while the block owns the pin |
| irq_pulse | output | 1 | Single-cycle interrupt pulse |

## Verification
Each mode is run against a timer sweeping a ten-count period for three periods. The bench records when the pin rises and falls and when interrupts occur. This separates the one-shots, which must react once, from the toggle and repeating-pulse modes, which must react every period, and shows the rise-versus-fall interrupt rule of each mode. In PWM, the secondary value is changed in mid-period to show that the fall moves only from the next period on. A single-cycle fault low in the guarded PWM mode, followed by a fault-free run and then a selector rewrite, shows the latch, its interrupt and how it is cleared. Mode entries are made from both pin levels to check the starting level of each mode and that no interrupt comes from the entry itself.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

  typedef enum logic [2:0] {
    MD_OFF        = 3'b000,
    MD_SHOT_RISE  = 3'b001,
    MD_SHOT_FALL  = 3'b010,
    MD_TOGGLE     = 3'b011,
    MD_PULSE_ONCE = 3'b100,
    MD_PULSE_REP  = 3'b101,
    MD_PWM        = 3'b110,
    MD_PWM_GUARD  = 3'b111
  } mode_e;

  // compare references: primary, secondary, active duty
  localparam int unsigned NREF     = 3;
  localparam int unsigned REF_PRI  = 0;
  localparam int unsigned REF_SEC  = 1;
  localparam int unsigned REF_DUTY = 2;

endpackage

// File: rtl/cmpout_match.sv
module cmpout_match
  import cmpout_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic             prd_hit,
  input  logic             reload,
  input  logic [CNT_W-1:0] cmp_pri,
  input  logic [CNT_W-1:0] cmp_sec,
  input  logic             fault_n,
  output logic [NREF-1:0]  hit,
  output logic             pri_nz,
  output logic             sec_nz,
  output logic             fault_low,
  output logic             fault_fall
);

  logic [CNT_W-1:0] duty_q, duty_n;
  logic             duty_en;
  logic             fault_q;
  logic [CNT_W-1:0] ref_v [NREF];

  // duty shadow loads only at a period boundary or on mode entry
  assign duty_en = prd_hit | reload;
  assign duty_n  = cmp_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      fault_q <= 1'b1;
    end else begin
      if (duty_en) duty_q <= duty_n;
      fault_q <= fault_n;
    end
  end

  assign ref_v[REF_PRI]  = cmp_pri;
  assign ref_v[REF_SEC]  = cmp_sec;
  assign ref_v[REF_DUTY] = duty_q;

  for (genvar i = 0; i < NREF; i++) begin : g_cmp
    assign hit[i] = (tmr_cnt == ref_v[i]);
  end

  assign pri_nz     = |cmp_pri;
  assign sec_nz     = |cmp_sec;
  assign fault_low  = ~fault_n;
  assign fault_fall = fault_q & ~fault_n;

endmodule

// File: rtl/cmpout_pin_ctl.sv
module cmpout_pin_ctl
  import cmpout_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  mode_e           mode_sel,
  input  logic [NREF-1:0] hit,
  input  logic            prd_hit,
  input  logic            pri_nz,
  input  logic            sec_nz,
  input  logic            fault_low,
  output mode_e           mode_q,
  output logic            mode_chg,
  output logic            pin_q,
  output logic            pin_nxt,
  output logic            done_q,
  output logic            flt_q
);

  mode_e mode_n;
  logic  done_n, flt_n;

  assign mode_chg = (mode_sel != mode_q);

  always_comb begin
    mode_n  = mode_q;
    pin_nxt = pin_q;
    done_n  = done_q;
    flt_n   = flt_q;
    if (mode_chg) begin
      mode_n = mode_sel;
      done_n = 1'b0;
      flt_n  = 1'b0;
      unique case (mode_sel)
        MD_SHOT_FALL:          pin_nxt = 1'b1;
        MD_TOGGLE:             pin_nxt = pin_q;
        MD_PWM, MD_PWM_GUARD:  pin_nxt = pri_nz;
        default:               pin_nxt = 1'b0;
      endcase
    end else begin
      unique case (mode_q)
        MD_SHOT_RISE: if (!done_q && hit[REF_PRI]) begin
          pin_nxt = 1'b1;
          done_n  = 1'b1;
        end
        MD_SHOT_FALL: if (!done_q && hit[REF_PRI]) begin
          pin_nxt = 1'b0;
          done_n  = 1'b1;
        end
        MD_TOGGLE: if (hit[REF_PRI]) pin_nxt = ~pin_q;
        MD_PULSE_ONCE, MD_PULSE_REP: if (!done_q) begin
          if (!pin_q && hit[REF_PRI]) begin
            pin_nxt = 1'b1;
          end else if (pin_q && hit[REF_SEC]) begin
            pin_nxt = 1'b0;
            done_n  = (mode_q == MD_PULSE_ONCE);
          end
        end
        MD_PWM, MD_PWM_GUARD: begin
          if (mode_q == MD_PWM_GUARD && (flt_q || fault_low)) begin
            flt_n   = 1'b1;
            pin_nxt = 1'b0;
          end else if (prd_hit) begin
            pin_nxt = sec_nz;
          end else if (hit[REF_DUTY]) begin
            pin_nxt = 1'b0;
          end
        end
        default: pin_nxt = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      pin_q  <= pin_nxt;
      done_q <= done_n;
      flt_q  <= flt_n;
    end
  end

endmodule

// File: rtl/cmpout_irq_gen.sv
module cmpout_irq_gen
  import cmpout_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_q,
  input  logic  mode_chg,
  input  logic  pin_q,
  input  logic  pin_nxt,
  input  logic  fault_fall,
  output logic  irq_q
);

  logic rise, fall, irq_n;

  assign rise = ~pin_q & pin_nxt;
  assign fall = pin_q & ~pin_nxt;

  always_comb begin
    irq_n = 1'b0;
    if (!mode_chg) begin
      unique case (mode_q)
        MD_SHOT_RISE:                irq_n = rise;
        MD_SHOT_FALL:                irq_n = fall;
        MD_TOGGLE:                   irq_n = rise | fall;
        MD_PULSE_ONCE, MD_PULSE_REP: irq_n = fall;
        MD_PWM_GUARD:                irq_n = fault_fall;
        default:                     irq_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

endmodule

// File: rtl/cmpout_top.sv
module cmpout_top
  import cmpout_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic             prd_hit,
  input  logic [2:0]       mode_sel,
  input  logic [CNT_W-1:0] cmp_pri,
  input  logic [CNT_W-1:0] cmp_sec,
  input  logic             fault_n,
  input  logic             gpio_val,
  output logic             pin_out,
  output logic             pin_drive,
  output logic             irq_pulse
);

  logic [1:0]      rst_pipe;
  logic            rst_s_n;
  logic [NREF-1:0] hit;
  logic            pri_nz, sec_nz, fault_low, fault_fall;
  mode_e           mode_cur;
  logic            mode_chg, pin_cur, pin_nxt, done_cur, flt_cur;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  cmpout_match #(.CNT_W(CNT_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tmr_cnt    (tmr_cnt),
    .prd_hit    (prd_hit),
    .reload     (mode_chg),
    .cmp_pri    (cmp_pri),
    .cmp_sec    (cmp_sec),
    .fault_n    (fault_n),
    .hit        (hit),
    .pri_nz     (pri_nz),
    .sec_nz     (sec_nz),
    .fault_low  (fault_low),
    .fault_fall (fault_fall)
  );

  cmpout_pin_ctl u_pin (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .mode_sel  (mode_e'(mode_sel)),
    .hit       (hit),
    .prd_hit   (prd_hit),
    .pri_nz    (pri_nz),
    .sec_nz    (sec_nz),
    .fault_low (fault_low),
    .mode_q    (mode_cur),
    .mode_chg  (mode_chg),
    .pin_q     (pin_cur),
    .pin_nxt   (pin_nxt),
    .done_q    (done_cur),
    .flt_q     (flt_cur)
  );

  cmpout_irq_gen u_irq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .mode_q     (mode_cur),
    .mode_chg   (mode_chg),
    .pin_q      (pin_cur),
    .pin_nxt    (pin_nxt),
    .fault_fall (fault_fall),
    .irq_q      (irq_pulse)
  );

  assign pin_drive = (mode_cur != MD_OFF);
  assign pin_out   = pin_drive ? pin_cur : gpio_val;

endmodule

// File: rtl/cmpout_chk.sv
module cmpout_chk
  import cmpout_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_sel,
  input mode_e      mode_q,
  input logic       done_q,
  input logic       flt_q,
  input logic       pin_out,
  input logic       irq_pulse
);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_OFF) |=> !irq_pulse);

  assert_rise_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && mode_q == MD_SHOT_RISE) |-> $rose(pin_out));

  assert_shot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SHOT_RISE && done_q && mode_sel == mode_q) |=> $stable(pin_out));

  assert_fall_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && mode_q == MD_SHOT_FALL) |-> $fell(pin_out));

  assert_pwm_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PWM) |=> !irq_pulse);

  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PWM_GUARD && flt_q && mode_sel == mode_q) |=> !pin_out);

endmodule

bind cmpout_top cmpout_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .mode_q    (mode_cur),
  .done_q    (done_cur),
  .flt_q     (flt_cur),
  .pin_out   (pin_out),
  .irq_pulse (irq_pulse)
);

// File: tb/cmpout_top_tb_top.sv
module cmpout_top_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] tmr_cnt;
  logic         prd_hit;
  logic [2:0]   mode_sel;
  logic [W-1:0] cmp_pri, cmp_sec;
  logic         fault_n, gpio_val;
  logic         pin_out, pin_drive, irq_pulse;

  int n_run = 0, n_fail = 0;
  int rises, falls, irqs, irq_at, first_rise, dbl_irq, chg_irqs;
  int fall_at [8];
  int last_pin;

  always #2 clk = ~clk;

  cmpout_top #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .prd_hit(prd_hit),
    .mode_sel(mode_sel), .cmp_pri(cmp_pri), .cmp_sec(cmp_sec),
    .fault_n(fault_n), .gpio_val(gpio_val),
    .pin_out(pin_out), .pin_drive(pin_drive), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // selector change with the timer parked on a non-matching count
  task automatic set_mode(input int m);
    mode_sel = m[2:0];
    tmr_cnt  = '1;
    prd_hit  = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (irq_pulse) chg_irqs++;
    end
  endtask

  // sweep the timer; sample k reflects the cycle whose count was k mod (P+1)
  task automatic run_win(input int P, input int ncyc, input int flt_at,
                         input int sec_at, input int sec_new);
    int prev, prev_irq;
    prev = int'(pin_out);
    prev_irq = 0;
    rises = 0; falls = 0; irqs = 0; irq_at = -1; first_rise = -1; dbl_irq = 0;
    for (int i = 0; i < 8; i++) fall_at[i] = -1;
    for (int k = 0; k < ncyc; k++) begin
      tmr_cnt = W'(k % (P + 1));
      prd_hit = ((k % (P + 1)) == P);
      fault_n = (k == flt_at) ? 1'b0 : 1'b1;
      if (k == sec_at) cmp_sec = W'(sec_new);
      @(negedge clk);
      if (pin_out && prev == 0) begin
        rises++;
        if (first_rise < 0) first_rise = k;
      end
      if (!pin_out && prev == 1) begin
        if (falls < 8) fall_at[falls] = k;
        falls++;
      end
      if (irq_pulse) begin
        irqs++;
        irq_at = k;
        if (prev_irq == 1) dbl_irq++;
      end
      prev_irq = int'(irq_pulse);
      prev = int'(pin_out);
    end
    last_pin = prev;
    tmr_cnt = '1;
    prd_hit = 1'b0;
    fault_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    chg_irqs = 0;
    rst_n = 1'b0; tmr_cnt = '1; prd_hit = 1'b0; mode_sel = 3'b000;
    cmp_pri = 16'd5; cmp_sec = 16'd7; fault_n = 1'b1; gpio_val = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 drive in reset", int'(pin_drive), 0);
    chk("R12 irq in reset", int'(irq_pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 drive after reset", int'(pin_drive), 0);

    // R1: off mode follows fallback, never interrupts
    gpio_val = 1'b1; #1;
    chk("R1 gpio high", int'(pin_out), 1);
    gpio_val = 1'b0; #1;
    chk("R1 gpio low", int'(pin_out), 0);
    @(negedge clk);
    run_win(9, 30, -1, -1, 0);
    chk("R1 irqs", irqs, 0);
    chk("R1 drive", int'(pin_drive), 0);

    // R2: rising one-shot at primary 5
    set_mode(1);
    chk("R2 drive", int'(pin_drive), 1);
    chk("R2 initial", int'(pin_out), 0);
    run_win(9, 30, -1, -1, 0);
    chk("R2 rises", rises, 1);
    chk("R2 rise time", first_rise, 5);
    chk("R2 falls", falls, 0);
    chk("R2 irqs", irqs, 1);
    chk("R2 irq time", irq_at, 5);

    // R4: toggle entered with pin high keeps it high
    set_mode(3);
    chk("R4 entry level", int'(pin_out), 1);
    run_win(9, 30, -1, -1, 0);
    chk("R4 edges", rises + falls, 3);
    chk("R4 irqs", irqs, 3);
    chk("R4 final", last_pin, 0);
    chk("R11 toggle irq width", dbl_irq, 0);

    // R3: falling one-shot entered from pin low
    set_mode(2);
    chk("R3 initial", int'(pin_out), 1);
    run_win(9, 30, -1, -1, 0);
    chk("R3 falls", falls, 1);
    chk("R3 fall time", fall_at[0], 5);
    chk("R3 irqs", irqs, 1);
    chk("R3 irq time", irq_at, 5);

    // R5: delayed one-shot, rise at 3, fall at 7
    cmp_pri = 16'd3; cmp_sec = 16'd7;
    set_mode(4);
    chk("R5 initial", int'(pin_out), 0);
    run_win(9, 30, -1, -1, 0);
    chk("R5 rises", rises, 1);
    chk("R5 rise time", first_rise, 3);
    chk("R5 falls", falls, 1);
    chk("R5 fall time", fall_at[0], 7);
    chk("R5 irqs", irqs, 1);
    chk("R5 irq time", irq_at, 7);

    // R6: repeating pulse
    set_mode(5);
    run_win(9, 30, -1, -1, 0);
    chk("R6 rises", rises, 3);
    chk("R6 falls", falls, 3);
    chk("R6 fall 2", fall_at[1], 17);
    chk("R6 fall 3", fall_at[2], 27);
    chk("R6 irqs", irqs, 3);

    // R7: PWM entry level from primary value
    cmp_pri = 16'd0; cmp_sec = 16'd4;
    set_mode(6);
    chk("R7 zero primary", int'(pin_out), 0);
    set_mode(0);
    cmp_pri = 16'd1;
    set_mode(6);
    chk("R7 nonzero primary", int'(pin_out), 1);

    // R8/R9: duty 4, rewritten to 2 mid-period at sample 12
    run_win(9, 30, -1, 12, 2);
    chk("R8 fall 1", fall_at[0], 4);
    chk("R8 fall 2 keeps old duty", fall_at[1], 14);
    chk("R8 fall 3 new duty", fall_at[2], 22);
    chk("R8 rises", rises, 3);
    chk("R8 rise time", first_rise, 9);
    chk("R9 irqs", irqs, 0);

    // R10: guarded PWM, one-cycle fault at sample 15
    cmp_sec = 16'd4;
    set_mode(0);
    set_mode(7);
    chk("R10 entry", int'(pin_out), 1);
    run_win(9, 30, 15, -1, 0);
    chk("R10 falls", falls, 2);
    chk("R10 rises", rises, 1);
    chk("R10 irqs", irqs, 1);
    chk("R10 irq time", irq_at, 15);
    chk("R10 latched low", last_pin, 0);
    run_win(9, 20, -1, -1, 0);
    chk("R10 latch holds", rises, 0);
    set_mode(0);
    set_mode(7);
    chk("R10 cleared by rewrite", int'(pin_out), 1);
    run_win(9, 10, -1, -1, 0);
    chk("R10 runs again", fall_at[0], 4);

    chk("R11 no irq on mode change", chg_irqs, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule